// File: doc/BRIEF.md
# Sequential-Equivalent Miss Cost Filter

This block keeps a running total of data-cache stall cycles, adjusted so that the total estimates what the same code would have spent on cache misses if it ran on a single core. A latency counter starts when an L1 data miss begins and runs until the miss is serviced. At that point the block decides, from the cause of the miss, whether the measured latency belongs in the total.

Coherence misses are discarded. These are misses whose tag was found in the cache but marked invalid. Misses that duplicate another core's miss are also discarded; such a miss shows up as a fill in the shared state. All other misses add their full measured latency.

An eviction of a loaded line that a logically later thread also holds would, in a sequential run, turn into a later miss that hits in L2. For each such eviction the block adds a fixed L2-hit cost. A squash of the running thread cancels the outstanding miss but never reduces the total.

Top module: `miss_cost_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the `dCache` total reads 0.
- R2: A miss whose `missStart` cycle is s and whose `missDone` cycle is d (d > s) has a latency of d − s + 1 cycles. When such a miss is kept, that latency is added to `dCache`, and the new value appears on the cycle after d.
- R3: When `tagInvalidHit` is 1 in the `missStart` cycle, the miss is a coherence miss and its latency is not added.
- R4: When `fillShared` is 1 in the `missDone` cycle, the miss duplicates another core's miss and its latency is not added.
- R5: There is one outstanding miss at a time. A `missStart` while a miss is outstanding is ignored, and the latency keeps counting from the first start. A `missDone` with no outstanding miss adds nothing.
- R6: An eviction (`evictValid` = 1) with `evictLaterShared` = 1 adds `L2_HIT_LAT` (default 18) to `dCache` on the next cycle. An eviction with `evictLaterShared` = 0 adds nothing.
- R7: When an eviction credit and a kept miss completion fall in the same cycle, both amounts are added together on the next cycle.
- R8: `squash` cancels the outstanding miss, so a later `missDone` adds nothing. It never lowers `dCache`, and an eviction credit in the same cycle is still added.
- R9: `dCache` saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missStart | input | 1 | An L1 data miss begins this cycle |
| tagInvalidHit | input | 1 | The missing line's tag matched an invalid entry (sampled with missStart) |
| missDone | input | 1 | The outstanding miss is serviced this cycle |
| fillShared | input | 1 | The line was filled in the shared state (sampled with missDone) |
| evictValid | input | 1 | A loaded line is evicted this cycle |
| evictLaterShared | input | 1 | The evicted line is also held by a logically later thread |
| squash | input | 1 | The running speculative thread is squashed |
| dCache | output | CNT_W | Accumulated sequential-equivalent miss cycles |

## Verification
Two functions can act in the same cycle: completing a miss and crediting an eviction. The bench provokes this by asserting `missDone` and a flagged eviction together, then expects the sum of both amounts one cycle later. It also combines a squash with a flagged eviction, and expects only the eviction credit to land. Saturation is reached by running the block with a narrow total width and applying repeated eviction credits until the sum would pass the all-ones value.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  // Strobes from the control half to the datapath half, one cycle's worth.
  typedef struct packed {
    logic startLat;   // load the latency counter with the first cycle
    logic incLat;     // count one more outstanding cycle
    logic clrLat;     // miss finished or was cancelled
    logic addMiss;    // fold the measured latency into the total
    logic addEvict;   // fold the fixed L2-hit cost into the total
  } mcfStrobes_t;

endpackage

// File: rtl/mcf_ctrl.sv
module mcf_ctrl
  import mcf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missStart,
  input  logic        tagInvalidHit,
  input  logic        missDone,
  input  logic        fillShared,
  input  logic        evictValid,
  input  logic        evictLaterShared,
  input  logic        squash,
  output mcfStrobes_t strobes
);

  logic pending;
  logic invTagReg;
  logic acceptStart;
  logic finishMiss;

  assign acceptStart = missStart && !pending && !squash;
  assign finishMiss  = pending && (missDone || squash);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      invTagReg <= 1'b0;
    end else begin
      if (acceptStart) begin
        pending   <= 1'b1;
        invTagReg <= tagInvalidHit;
      end else if (finishMiss) begin
        pending   <= 1'b0;
        invTagReg <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.startLat = acceptStart;
    strobes.incLat   = pending && !missDone && !squash;
    strobes.clrLat   = finishMiss;
    strobes.addMiss  = pending && missDone && !squash && !invTagReg && !fillShared;
    strobes.addEvict = evictValid && evictLaterShared;
  end

endmodule

// File: rtl/mcf_datapath.sv
module mcf_datapath
  import mcf_pkg::*;
#(
  parameter int LAT_W      = 12,
  parameter int CNT_W      = 32,
  parameter int L2_HIT_LAT = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  mcfStrobes_t      strobes,
  output logic [CNT_W-1:0] dCache
);

  localparam int WIDE_IN = (CNT_W > LAT_W + 1) ? CNT_W : LAT_W + 1;
  localparam int SUM_W   = WIDE_IN + 2;
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  logic [LAT_W-1:0] latReg;
  logic [LAT_W:0]   missAmt;
  logic [SUM_W-1:0] missTerm;
  logic [SUM_W-1:0] evictTerm;
  logic [SUM_W-1:0] sumWide;

  // Latency counter: the start cycle counts as one, the done cycle adds one more.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latReg <= '0;
    end else if (strobes.startLat) begin
      latReg <= LAT_W'(1);
    end else if (strobes.clrLat) begin
      latReg <= '0;
    end else if (strobes.incLat && latReg != LAT_MAX) begin
      latReg <= latReg + 1'b1;
    end
  end

  assign missAmt   = {1'b0, latReg} + 1'b1;
  assign missTerm  = strobes.addMiss  ? SUM_W'(missAmt)    : '0;
  assign evictTerm = strobes.addEvict ? SUM_W'(L2_HIT_LAT) : '0;
  assign sumWide   = SUM_W'(dCache) + missTerm + evictTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dCache <= '0;
    end else if (sumWide > CNT_MAX) begin
      dCache <= {CNT_W{1'b1}};
    end else begin
      dCache <= sumWide[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/miss_cost_filter.sv
module miss_cost_filter
  import mcf_pkg::*;
#(
  parameter int LAT_W      = 12,
  parameter int CNT_W      = 32,
  parameter int L2_HIT_LAT = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missStart,
  input  logic             tagInvalidHit,
  input  logic             missDone,
  input  logic             fillShared,
  input  logic             evictValid,
  input  logic             evictLaterShared,
  input  logic             squash,
  output logic [CNT_W-1:0] dCache
);

  mcfStrobes_t strobes;

  mcf_ctrl uCtrl (
    .clk              (clk),
    .rstN             (rstN),
    .missStart        (missStart),
    .tagInvalidHit    (tagInvalidHit),
    .missDone         (missDone),
    .fillShared       (fillShared),
    .evictValid       (evictValid),
    .evictLaterShared (evictLaterShared),
    .squash           (squash),
    .strobes          (strobes)
  );

  mcf_datapath #(
    .LAT_W      (LAT_W),
    .CNT_W      (CNT_W),
    .L2_HIT_LAT (L2_HIT_LAT)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dCache  (dCache)
  );

endmodule

// File: rtl/miss_cost_filter_chk.sv
module miss_cost_filter_chk #(
  parameter int CNT_W      = 32,
  parameter int L2_HIT_LAT = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             missDone,
  input logic             fillShared,
  input logic             evictValid,
  input logic             evictLaterShared,
  input logic             squash,
  input logic [CNT_W-1:0] dCache
);

  localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

  logic credit;
  logic roomForCredit;
  assign credit        = evictValid && evictLaterShared;
  assign roomForCredit = ({1'b0, dCache} + (CNT_W+1)'(L2_HIT_LAT)) <= MAXV;

  AST_RESET_ZERO: assert property (@(posedge clk) !rstN |=> dCache == '0); // R1

  AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!missDone && !credit) |=> dCache == $past(dCache)); // R2

  AST_SHARED_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (missDone && fillShared && !credit) |=> dCache == $past(dCache)); // R4

  AST_EVICT_CREDIT: assert property (@(posedge clk) disable iff (!rstN)
    (credit && !missDone && roomForCredit) |=> dCache == $past(dCache) + CNT_W'(L2_HIT_LAT)); // R6

  AST_SQUASH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (squash && !credit) |=> dCache == $past(dCache)); // R8

  AST_NEVER_DECREASES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> dCache >= $past(dCache)); // R9

endmodule

bind miss_cost_filter miss_cost_filter_chk #(
  .CNT_W      (CNT_W),
  .L2_HIT_LAT (L2_HIT_LAT)
) uChk (
  .clk              (clk),
  .rstN             (rstN),
  .missDone         (missDone),
  .fillShared       (fillShared),
  .evictValid       (evictValid),
  .evictLaterShared (evictLaterShared),
  .squash           (squash),
  .dCache           (dCache)
);

// File: tb/tb_miss_cost_filter.sv
module tb_miss_cost_filter;

  localparam int CW  = 10;
  localparam int LW  = 8;
  localparam int L2L = 18;
  localparam int NV  = 7;

  // Vector: {tagInvalidHit, fillShared, latency}; expected delta derives from R2-R4.
  typedef struct packed {
    logic       inv;
    logic       shr;
    logic [7:0] lat;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd2},
    '{1'b0, 1'b0, 8'd5},
    '{1'b1, 1'b0, 8'd7},
    '{1'b0, 1'b1, 8'd6},
    '{1'b1, 1'b1, 8'd4},
    '{1'b0, 1'b0, 8'd13},
    '{1'b0, 1'b0, 8'd3}
  };

  logic clk = 1'b0;
  logic rstN, missStart, tagInvalidHit, missDone, fillShared;
  logic evictValid, evictLaterShared, squash;
  logic [CW-1:0] dCache;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  miss_cost_filter #(.LAT_W(LW), .CNT_W(CW), .L2_HIT_LAT(L2L)) dut (
    .clk(clk), .rstN(rstN), .missStart(missStart), .tagInvalidHit(tagInvalidHit),
    .missDone(missDone), .fillShared(fillShared), .evictValid(evictValid),
    .evictLaterShared(evictLaterShared), .squash(squash), .dCache(dCache)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then advance to the next falling edge.
  task automatic cyc(input logic st, input logic inv, input logic dn, input logic sh,
                     input logic ev, input logic evs, input logic sq);
    missStart = st; tagInvalidHit = inv; missDone = dn; fillShared = sh;
    evictValid = ev; evictLaterShared = evs; squash = sq;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic runMiss(input logic inv, input logic sh, input int lat, input logic evCredit);
    cyc(1, inv, 0, 0, 0, 0, 0);
    for (int k = 0; k < lat - 2; k++) idle();
    cyc(0, 0, 1, sh, evCredit, evCredit, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(); idle();
    check("R1 during reset", int'(dCache), 0);
    rstN = 1'b1;
    idle();
    check("R1 after release", int'(dCache), 0);
    model = 0;
  endtask

  initial begin
    rstN = 1'b0;
    missStart = 0; tagInvalidHit = 0; missDone = 0; fillShared = 0;
    evictValid = 0; evictLaterShared = 0; squash = 0;
    @(negedge clk);
    doReset();

    // Table walk: R2 kept misses, R3 coherence drops, R4 shared-fill drops.
    for (int i = 0; i < NV; i++) begin
      runMiss(VECS[i].inv, VECS[i].shr, int'(VECS[i].lat), 1'b0);
      if (!VECS[i].inv && !VECS[i].shr) model += int'(VECS[i].lat);
      check(VECS[i].inv ? "R3 table" : (VECS[i].shr ? "R4 table" : "R2 table"),
            int'(dCache), model);
      idle();
    end

    // R6: flagged eviction credits L2 latency; unflagged does nothing.
    cyc(0, 0, 0, 0, 1, 1, 0);
    model += L2L;
    check("R6 flagged eviction", int'(dCache), model);
    cyc(0, 0, 0, 0, 1, 0, 0);
    check("R6 unflagged eviction", int'(dCache), model);

    // R7: miss completion and eviction credit together.
    runMiss(0, 0, 6, 1'b1);
    model += 6 + L2L;
    check("R7 coincident credit", int'(dCache), model);
    // Coincident credit with a dropped (shared) miss: only the credit lands.
    runMiss(0, 1, 4, 1'b1);
    model += L2L;
    check("R7 credit with dropped miss", int'(dCache), model);

    // R5: done with nothing outstanding, then a repeated start.
    cyc(0, 0, 1, 0, 0, 0, 0);
    check("R5 stray done", int'(dCache), model);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    idle();
    cyc(0, 0, 1, 0, 0, 0, 0);
    model += 4;
    check("R5 second start ignored", int'(dCache), model);

    // R8: squash cancels the miss and keeps the total.
    cyc(1, 0, 0, 0, 0, 0, 0);
    idle();
    cyc(0, 0, 0, 0, 0, 0, 1);
    check("R8 squash keeps total", int'(dCache), model);
    cyc(0, 0, 1, 0, 0, 0, 0);
    check("R8 done after squash", int'(dCache), model);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 1);
    model += L2L;
    check("R8 squash with credit", int'(dCache), model);
    runMiss(0, 0, 3, 1'b0);
    model += 3;
    check("R8 miss after squash", int'(dCache), model);

    // R9: saturation with a fresh total.
    doReset();
    for (int k = 0; k < 57; k++) cyc(0, 0, 0, 0, 1, 1, 0);
    check("R9 saturates", int'(dCache), (1 << CW) - 1);
    runMiss(0, 0, 5, 1'b0);
    check("R9 stays saturated", int'(dCache), (1 << CW) - 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule